// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

The controller gathers a set of peripheral interrupt request lines and drives one interrupt output toward a processor that has a single interrupt input. Each request line passes through a two-flop synchronizer. A rising edge on the line sets a pending bit for that source, and the bit stays set until the processor acknowledges that source. Software controls delivery through four things: a per-source enable mask, a global enable, a priority threshold and an in-service stack. Source 0 is non-maskable and bypasses all three gates.

Priority is fixed by index: the lowest index is the most urgent. When the processor raises the acknowledge strobe, the source presented at that moment is accepted. Its pending bit is cleared and its index is pushed onto an in-service stack. While a handler is in service, only a source of strictly higher priority than the top of the stack can be presented. Software writes an end-of-interrupt register to pop the stack. The output vector index tells the handler dispatch code which table entry to use.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A rising edge on `reqIn[i]` sets pending bit i. After the input goes high, the bit appears on the third rising clock edge (two synchronizer flops, then the pending register). A level held high sets the bit only once.
- R2: A pending bit whose source is disabled is kept. The source is presented as soon as it becomes enabled again.
- R3: A source i other than 0 can be presented only when both of these are 1: mask bit i (register 0, bit i) and the global enable (register 1, bit 0).
- R4: Source 0 is non-maskable. It ignores the mask, the global enable and the threshold.
- R5: A source i other than 0 can be presented only when i is less than or equal to the threshold (register 2, low bits). After reset the threshold is NUM_SRC-1.
- R6: Among the eligible pending sources, the one with the lowest index is presented, and `vecIdx` carries that index.
- R7: When `ackStrobe` is high at a clock edge while `irqOut` is high, the pending bit of the presented source is cleared and its index is pushed onto the in-service stack. An acknowledge while `irqOut` is low has no effect.
- R8: While the stack is not empty and its top holds index t, only a source with index less than t can be presented. A write of any value to register 4 pops the stack.
- R9: `irqOut` is high exactly when at least one eligible pending source exists. In that case `vecIdx` stays valid.
- R10: Register 3 reads the pending vector. Register 4 reads the in-service stack depth. Registers 0, 1 and 2 read back the last value written to them.
- R11: Reset clears the pending bits, the mask, the global enable and the stack depth, sets the threshold to NUM_SRC-1, and drives `irqOut` low.
- R12: While the in-service stack holds NEST_DEPTH entries, no source is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqIn | input | NUM_SRC | Asynchronous peripheral request lines |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register index |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Register read data (combinational on regAddr) |
| ackStrobe | input | 1 | Processor acknowledge of the presented vector |
| irqOut | output | 1 | Interrupt request to the processor |
| vecIdx | output | $clog2(NUM_SRC) | Index of the presented source |

## Verification
The bench builds the block with eight sources and a nesting depth of only two. With the small depth, the full-stack hold-off condition is reached after two acknowledges, while the non-maskable source is still pending. At the default depth that condition could never occur. Eight sources give enough room to check threshold cut-offs, mask-versus-global interaction and three-deep priority ordering, and the nesting sequence lets a pending lower source wait through two end-of-interrupt pops.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

  typedef enum logic [2:0] {
    REG_MASK = 3'd0,
    REG_CTRL = 3'd1,
    REG_THR  = 3'd2,
    REG_PEND = 3'd3,
    REG_SVC  = 3'd4
  } irqReg_t;

  typedef struct packed {
    logic wrMask;
    logic wrCtrl;
    logic wrThr;
    logic ack;
    logic eoi;
  } irqStrobes_t;

endpackage

// File: rtl/irq_req_sync.sv
module irq_req_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] reqIn,
  output logic [WIDTH-1:0] reqRise
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;
  logic [WIDTH-1:0] stagePrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage1    <= '0;
      stage2    <= '0;
      stagePrev <= '0;
    end else begin
      stage1    <= reqIn;
      stage2    <= stage1;
      stagePrev <= stage2;
    end
  end

  assign reqRise = stage2 & ~stagePrev;
endmodule

// File: rtl/irq_prio_datapath.sv
module irq_prio_datapath
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int NEST_DEPTH = 8,
  parameter int DATA_W     = 16,
  localparam int IDXW = $clog2(NUM_SRC),
  localparam int PRIW = $clog2(NUM_SRC + 1),
  localparam int CW   = $clog2(NEST_DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  irqStrobes_t         stb,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [NUM_SRC-1:0]  reqRise,
  output logic                irqOut,
  output logic [IDXW-1:0]     vecIdx,
  output logic [NUM_SRC-1:0]  maskReg,
  output logic                gEn,
  output logic [IDXW-1:0]     thrReg,
  output logic [NUM_SRC-1:0]  pend,
  output logic [CW-1:0]       depth
);
  logic [IDXW-1:0]    stk [NEST_DEPTH];
  logic [PRIW-1:0]    curPri;
  logic [NUM_SRC-1:0] elig;
  logic               stackFull;
  logic               doPush;
  logic               doPop;
  logic [CW-1:0]      pushSlot;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= '0;
      gEn     <= 1'b0;
      thrReg  <= IDXW'(NUM_SRC - 1);
    end else begin
      if (stb.wrMask) maskReg <= wrData[NUM_SRC-1:0];
      if (stb.wrCtrl) gEn     <= wrData[0];
      if (stb.wrThr)  thrReg  <= wrData[IDXW-1:0];
    end
  end

  // pending bits: a new edge wins over a same-cycle acknowledge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend <= '0;
    end else begin
      for (int i = 0; i < NUM_SRC; i++) begin
        if (reqRise[i])
          pend[i] <= 1'b1;
        else if (stb.ack && vecIdx == IDXW'(i))
          pend[i] <= 1'b0;
      end
    end
  end

  // in-service stack
  assign stackFull = (depth == CW'(NEST_DEPTH));
  assign doPush    = stb.ack;
  assign doPop     = stb.eoi && (depth != '0);
  assign pushSlot  = doPop ? depth - CW'(1) : depth;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      depth <= '0;
    end else if (doPush && !doPop) begin
      depth <= depth + CW'(1);
    end else if (doPop && !doPush) begin
      depth <= depth - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < NEST_DEPTH; e++) stk[e] <= '0;
    end else begin
      for (int e = 0; e < NEST_DEPTH; e++)
        if (doPush && pushSlot == CW'(e)) stk[e] <= vecIdx;
    end
  end

  always_comb begin
    curPri = PRIW'(NUM_SRC);
    for (int e = 0; e < NEST_DEPTH; e++)
      if (depth == CW'(e + 1)) curPri = PRIW'(stk[e]);
  end

  // per-source eligibility
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
    if (i == 0) begin : g_nmi
      assign elig[i] = pend[i] && (PRIW'(i) < curPri) && !stackFull;
    end else begin : g_mask
      assign elig[i] = pend[i] && gEn && maskReg[i] && (IDXW'(i) <= thrReg)
                       && (PRIW'(i) < curPri) && !stackFull;
    end

    p_pend_kept_r2: assert property (@(posedge clk) disable iff (!rstN)
      (pend[i] && !(stb.ack && vecIdx == IDXW'(i))) |=> pend[i]);

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
      (stb.ack && vecIdx == IDXW'(i) && !reqRise[i]) |=> !pend[i]);
  end

  // fixed priority: lowest index wins
  always_comb begin
    vecIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (elig[i]) vecIdx = IDXW'(i);
  end

  assign irqOut = |elig;

  p_masked_r3: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && vecIdx != '0) |-> (gEn && maskReg[vecIdx]));

  p_nmi_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pend[0] && depth == '0) |-> (irqOut && vecIdx == '0));

  p_thresh_r5: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut && vecIdx != '0) |-> (vecIdx <= thrReg));

  p_push_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ack && !stb.eoi) |=> (depth == $past(depth) + CW'(1)));

  p_pop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.eoi && !stb.ack && depth != '0) |=> (depth == $past(depth) - CW'(1)));

  p_preempt_strict_r8: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (PRIW'(vecIdx) < curPri));

  p_full_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (depth == CW'(NEST_DEPTH)) |-> !irqOut);
endmodule

// File: rtl/irq_prio_control.sv
module irq_prio_control
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int NEST_DEPTH = 8,
  parameter int DATA_W     = 16,
  localparam int IDXW = $clog2(NUM_SRC),
  localparam int CW   = $clog2(NEST_DEPTH + 1)
) (
  input  logic               regWrEn,
  input  logic [2:0]         regAddr,
  input  logic               ackStrobe,
  input  logic               irqOut,
  input  logic [NUM_SRC-1:0] maskReg,
  input  logic               gEn,
  input  logic [IDXW-1:0]    thrReg,
  input  logic [NUM_SRC-1:0] pend,
  input  logic [CW-1:0]      depth,
  output irqStrobes_t        stb,
  output logic [DATA_W-1:0]  regRdData
);
  always_comb begin
    stb        = '0;
    stb.ack    = ackStrobe && irqOut;
    stb.wrMask = regWrEn && (regAddr == REG_MASK);
    stb.wrCtrl = regWrEn && (regAddr == REG_CTRL);
    stb.wrThr  = regWrEn && (regAddr == REG_THR);
    stb.eoi    = regWrEn && (regAddr == REG_SVC);
  end

  always_comb begin
    case (regAddr)
      REG_MASK: regRdData = DATA_W'(maskReg);
      REG_CTRL: regRdData = DATA_W'(gEn);
      REG_THR:  regRdData = DATA_W'(thrReg);
      REG_PEND: regRdData = DATA_W'(pend);
      REG_SVC:  regRdData = DATA_W'(depth);
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int NEST_DEPTH = 8,
  parameter int DATA_W     = 16,
  localparam int IDXW = $clog2(NUM_SRC),
  localparam int CW   = $clog2(NEST_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] reqIn,
  input  logic               regWrEn,
  input  logic [2:0]         regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic               ackStrobe,
  output logic               irqOut,
  output logic [IDXW-1:0]    vecIdx
);
  irqStrobes_t        stb;
  logic [NUM_SRC-1:0] reqRise;
  logic [NUM_SRC-1:0] maskReg;
  logic [NUM_SRC-1:0] pend;
  logic               gEn;
  logic [IDXW-1:0]    thrReg;
  logic [CW-1:0]      depth;

  irq_req_sync #(.WIDTH(NUM_SRC)) u_sync (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .reqRise(reqRise)
  );

  irq_prio_control #(.NUM_SRC(NUM_SRC), .NEST_DEPTH(NEST_DEPTH), .DATA_W(DATA_W)) u_ctl (
    .regWrEn(regWrEn), .regAddr(regAddr), .ackStrobe(ackStrobe), .irqOut(irqOut),
    .maskReg(maskReg), .gEn(gEn), .thrReg(thrReg), .pend(pend), .depth(depth),
    .stb(stb), .regRdData(regRdData)
  );

  irq_prio_datapath #(.NUM_SRC(NUM_SRC), .NEST_DEPTH(NEST_DEPTH), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWrData), .reqRise(reqRise),
    .irqOut(irqOut), .vecIdx(vecIdx), .maskReg(maskReg), .gEn(gEn),
    .thrReg(thrReg), .pend(pend), .depth(depth)
  );
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;
  localparam int DW   = 16;
  localparam int NVEC = 9;
  // {mask[7:0], gEn, thr[2:0], req[7:0], expIrq, expVec[2:0]}
  localparam logic [23:0] VECS [NVEC] = '{
    24'hFFF30C, // R6: 4 and 5 pending, 4 wins
    24'hFF7300, // R3: global disable blocks
    24'hEFF30D, // R3: source 4 masked, 5 presented
    24'h000818, // R4: non-maskable through everything
    24'hFFBF00, // R5: threshold 3 blocks 4..7
    24'hFFCF0C, // R5: threshold 4 admits 4
    24'hFFF069, // R6: 1 beats 2
    24'h80F80F, // R3: only source 7 enabled
    24'h0FFF00  // R3: mask excludes 4..7
  };

  logic clk = 0, rstN = 0, regWrEn = 0, ackStrobe = 0, irqOut;
  logic [NSRC-1:0] reqIn = '0;
  logic [2:0] regAddr = '0;
  logic [DW-1:0] regWrData = '0, regRdData;
  logic [2:0] vecIdx;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_ctrl #(.NUM_SRC(NSRC), .NEST_DEPTH(2), .DATA_W(DW)) u_irq_prio_ctrl (
    .clk(clk), .rstN(rstN), .reqIn(reqIn), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .ackStrobe(ackStrobe),
    .irqOut(irqOut), .vecIdx(vecIdx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 0; reqIn = '0; regWrEn = 0; ackStrobe = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk); regWrEn = 1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic rdReg(input logic [2:0] a, output int d);
    regAddr = a; #1; d = int'(regRdData);
  endtask

  task automatic ack();
    @(negedge clk); ackStrobe = 1;
    @(negedge clk); ackStrobe = 0;
  endtask

  task automatic pulse(input logic [NSRC-1:0] bits);
    @(negedge clk); reqIn = reqIn | bits;
    repeat (3) @(negedge clk);
    reqIn = reqIn & ~bits;
  endtask

  task automatic expIrq(input string tag, input logic e, input int v);
    chk({tag, " irq"}, int'(irqOut), int'(e));
    if (e) chk({tag, " vec"}, int'(vecIdx), v);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int d;
    // table-driven walk
    for (int k = 0; k < NVEC; k++) begin
      doReset();
      wrReg(3'd0, DW'(VECS[k][23:16]));
      wrReg(3'd1, DW'(VECS[k][15]));
      wrReg(3'd2, DW'(VECS[k][14:12]));
      pulse(VECS[k][11:4]);
      @(negedge clk);
      expIrq($sformatf("R6/R9 vec%0d", k), VECS[k][3], int'(VECS[k][2:0]));
      rdReg(3'd3, d);
      chk($sformatf("R2/R10 pend vec%0d", k), d, int'(VECS[k][11:4]));
    end

    // R11 reset values
    doReset();
    @(negedge clk);
    chk("R11 irq", int'(irqOut), 0);
    rdReg(3'd0, d); chk("R11 mask", d, 0);
    rdReg(3'd1, d); chk("R11 ctrl", d, 0);
    rdReg(3'd2, d); chk("R11 thr", d, 7);
    rdReg(3'd3, d); chk("R11 pend", d, 0);
    rdReg(3'd4, d); chk("R11 depth", d, 0);

    wrReg(3'd0, 16'hFF);
    wrReg(3'd1, 16'h1);
    rdReg(3'd0, d); chk("R10 mask readback", d, 255);

    // R1 latency: three edges
    @(negedge clk); reqIn[2] = 1;
    @(negedge clk); chk("R1 edge1", int'(irqOut), 0);
    @(negedge clk); chk("R1 edge2", int'(irqOut), 0);
    @(negedge clk); expIrq("R1 edge3", 1, 2);
    ack();
    rdReg(3'd3, d); chk("R7 pend cleared", d, 0);
    rdReg(3'd4, d); chk("R7 depth push", d, 1);
    wrReg(3'd4, 16'h0);
    repeat (3) @(negedge clk);
    chk("R1 held level once", int'(irqOut), 0);
    rdReg(3'd3, d); chk("R1 held level pend", d, 0);
    reqIn[2] = 0;
    repeat (3) @(negedge clk);

    // R2 latched while masked
    wrReg(3'd0, 16'hF7);
    pulse(8'h08);
    @(negedge clk);
    chk("R2 masked no irq", int'(irqOut), 0);
    rdReg(3'd3, d); chk("R2 kept pending", d, 8);
    wrReg(3'd0, 16'hFF);
    expIrq("R2 delivered", 1, 3);
    ack();

    // R8 nesting
    pulse(8'h20);
    @(negedge clk);
    chk("R8 lower blocked", int'(irqOut), 0);
    pulse(8'h02);
    @(negedge clk);
    expIrq("R8 higher preempts", 1, 1);
    ack();
    rdReg(3'd4, d); chk("R8 depth two", d, 2);
    // R12 full stack holds off source 0
    pulse(8'h01);
    @(negedge clk);
    chk("R12 full holds", int'(irqOut), 0);
    rdReg(3'd3, d); chk("R12 pend", d, 33);
    wrReg(3'd4, 16'h0);
    expIrq("R4 nmi after pop", 1, 0);
    ack();
    chk("R8 after nmi ack", int'(irqOut), 0);
    wrReg(3'd4, 16'h0);
    chk("R8 top 3 blocks 5", int'(irqOut), 0);
    wrReg(3'd4, 16'h0);
    expIrq("R8 empty stack", 1, 5);
    ack();
    chk("R9 none left", int'(irqOut), 0);
    wrReg(3'd4, 16'h0);
    rdReg(3'd4, d); chk("R8 depth zero", d, 0);

    // R7 ack with irqOut low ignored
    ack();
    rdReg(3'd4, d); chk("R7 idle ack ignored", d, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule